// File: doc/BRIEF.md
# Audio Noise Gate Controller

This block watches a per-sample level estimate of an audio stream and closes a noise gate once the level has stayed under a programmable threshold without a break for a quarter of a second. The level detector sits upstream and the gain stage sits downstream. This block only decides when to gate and drives three controls: a flag that freezes the gain, a digital mute flag, and a gain request code that can ramp down to its floor and back up.

The level arrives as an unsigned attenuation below full scale in 0.5 dB units, so level code L means −L/2 dB. A 5-bit threshold code sets the gate point in 1.5 dB steps. A 2-bit action code picks what the gate does once it closes: freeze the gain, mute, fade down, or fade down and then mute. The quarter-second window is counted in sample strobes, and its length comes from the sample-rate parameter.

Top module: `noise_gate_ctrl`

## Requirements
- R1: A sample counts as below threshold when `level_i > 153 − 3·thr_code`. This places code 0 at −76.5 dB and code 31 at −30 dB, with 1.5 dB per code. A level equal to that limit counts as at threshold.
- R2: The gate closes on the strobe that completes `SAMPLE_RATE_HZ/4` consecutive below-threshold strobes. Any strobe at or above threshold restarts the count.
- R3: With action code 0, a closed gate raises `hold_o`. The gain request stays unchanged and `mute_o` stays low.
- R4: With action code 1, a closed gate raises `mute_o` and leaves the gain request unchanged.
- R5: With action code 2, a closed gate lowers `gain_req_o` by one code (0.75 dB) once every `FADE_DIV` strobes until it reaches 0. `mute_o` stays low.
- R6: With action code 3, the gain fades as in R5. `mute_o` rises on the first strobe that finds the gain already at 0.
- R7: A strobe at or above threshold while the gate is closed clears `hold_o` and `mute_o` one cycle later. The gain request then climbs back to full scale (`2^GAIN_W−1`) one code every `FADE_DIV` strobes.
- R8: While `gate_en` is low, and after reset, `hold_o` and `mute_o` are low and `gain_req_o` is at full scale.
- R9: A change of `gate_en` or `gate_type` returns the gate to idle. The gate flags drop and the below-threshold count starts again from zero.
- R10: Cycles without a strobe advance neither the count, the gate state nor the gain ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | One-cycle strobe per audio sample |
| level_i | input | LVL_W | Level as attenuation in 0.5 dB units |
| gate_en | input | 1 | Gate enable |
| gate_type | input | 2 | Action: 0 hold, 1 mute, 2 fade, 3 fade then mute |
| thr_code | input | 5 | Threshold code, 1.5 dB per step |
| hold_o | output | 1 | Freeze-gain request |
| mute_o | output | 1 | Digital mute request |
| gain_req_o | output | GAIN_W | Gain request code, 0.75 dB per step |

## Verification
The assertions assume that `smp_stb` is a single-cycle pulse. They also assume that `level_i` and `thr_code` are stable on a strobe edge, and that `gate_type` changes only through the `gate_en`/type change path, whose one-cycle flush they check. The stimulus drives every input on the falling clock edge and separates strobes by at least one idle cycle. It moves configuration only between strobes, with a settling cycle after each change, and runs at a reduced sample-rate parameter so that the full gating window, fades and releases fit in a short run.

// File: rtl/ng_pkg.sv
package ng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_COUNT = 2'd1,
    ST_GATED = 2'd2,
    ST_MUTED = 2'd3
  } ng_state_e;

  typedef enum logic [1:0] {
    ACT_HOLD      = 2'b00,
    ACT_MUTE      = 2'b01,
    ACT_FADE      = 2'b10,
    ACT_FADE_MUTE = 2'b11
  } ng_act_e;

  localparam int THR_BASE_UNITS = 153;
  localparam int THR_STEP_UNITS = 3;

  // Threshold code -> attenuation limit in 0.5 dB units
  function automatic logic [7:0] thr_to_atten(input logic [4:0] code);
    logic [7:0] step;
    step = 8'(THR_STEP_UNITS) * {3'b000, code};
    return 8'(THR_BASE_UNITS) - step;
  endfunction

  // Whether an action fades the gain while in a given state
  function automatic logic fades_in(input ng_state_e st, input ng_act_e act);
    return ((st == ST_GATED) && (act == ACT_FADE || act == ACT_FADE_MUTE)) ||
           ((st == ST_MUTED) && (act == ACT_FADE_MUTE));
  endfunction

endpackage

// File: rtl/ng_level_cmp.sv
module ng_level_cmp
  import ng_pkg::*;
#(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0] level_i,
  input  logic [4:0]       thr_code,
  output logic             below_o
);

  localparam int PAD_W = (LVL_W > 8) ? LVL_W : 8;

  logic [PAD_W-1:0] lvl_ext;
  logic [PAD_W-1:0] lim_ext;

  always_comb begin
    lvl_ext = PAD_W'(level_i);
    lim_ext = PAD_W'(thr_to_atten(thr_code));
    below_o = lvl_ext > lim_ext;
  end

endmodule

// File: rtl/ng_gate_fsm.sv
module ng_gate_fsm
  import ng_pkg::*;
#(
  parameter int HOLD_SAMPLES = 12000,
  localparam int CNT_W = $clog2(HOLD_SAMPLES + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      smp_stb,
  input  logic      below,
  input  logic      gate_en,
  input  logic [1:0] gate_type,
  input  logic      gain_at_min,
  output ng_state_e state_q,
  output logic      fade_dn,
  output logic      hold_o,
  output logic      mute_o
);

  ng_act_e         act;
  logic [2:0]      cfg_q;
  logic            cfg_chg;
  logic [CNT_W-1:0] cnt_q;
  logic            window_done;
  logic            release_ev;
  ng_state_e       gate_st;

  assign act         = ng_act_e'(gate_type);
  assign cfg_chg     = {gate_en, gate_type} != cfg_q;
  assign window_done = (cnt_q == CNT_W'(HOLD_SAMPLES - 1));
  assign release_ev  = smp_stb && !below;
  assign gate_st     = (act == ACT_MUTE) ? ST_MUTED : ST_GATED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= {gate_en, gate_type};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (!gate_en || cfg_chg) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else if (smp_stb) begin
      unique case (state_q)
        ST_IDLE, ST_COUNT: begin
          if (!below) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
          end else if (window_done) begin
            state_q <= gate_st;
            cnt_q   <= '0;
          end else begin
            state_q <= ST_COUNT;
            cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_GATED: begin
          if (release_ev)
            state_q <= ST_IDLE;
          else if (act == ACT_FADE_MUTE && gain_at_min)
            state_q <= ST_MUTED;
        end
        ST_MUTED: begin
          if (release_ev) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fade_dn = fades_in(state_q, act);
  assign hold_o  = (state_q == ST_GATED) && (act == ACT_HOLD);
  assign mute_o  = (state_q == ST_MUTED);

  AST_DIS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (state_q == ST_IDLE)); // R8

  AST_CFG_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_chg |=> (state_q == ST_IDLE)); // R9

  AST_MUTE_ON_STB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mute_o) |-> $past(smp_stb)); // R10

  AST_FM_AT_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mute_o) && act == ACT_FADE_MUTE && $past(act) == ACT_FADE_MUTE) |-> gain_at_min); // R6

  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ev && gate_en && !cfg_chg) |=> (!mute_o && !hold_o)); // R7

endmodule

// File: rtl/ng_gain_ramp.sv
module ng_gain_ramp #(
  parameter int GAIN_W   = 6,
  parameter int FADE_DIV = 4,
  localparam int DIV_W    = $clog2(FADE_DIV + 1),
  localparam logic [GAIN_W-1:0] GAIN_TOP = {GAIN_W{1'b1}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic              snap,
  input  logic              fade_dn,
  output logic [GAIN_W-1:0] gain_q,
  output logic              at_min
);

  logic [DIV_W-1:0]  div_q;
  logic [GAIN_W-1:0] target;
  logic              at_target;
  logic              step_ev;

  assign target    = fade_dn ? '0 : GAIN_TOP;
  assign at_target = (gain_q == target);
  assign step_ev   = smp_stb && !at_target && (div_q == DIV_W'(FADE_DIV - 1));
  assign at_min    = (gain_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q <= GAIN_TOP;
      div_q  <= '0;
    end else if (snap) begin
      gain_q <= GAIN_TOP;
      div_q  <= '0;
    end else if (smp_stb) begin
      if (at_target) begin
        div_q <= '0;
      end else if (step_ev) begin
        div_q  <= '0;
        gain_q <= fade_dn ? gain_q - 1'b1 : gain_q + 1'b1;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end
  end

  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(snap) && !$stable(gain_q)) |->
      ((gain_q == $past(gain_q) + 1'b1) || (gain_q == $past(gain_q) - 1'b1))); // R5

  AST_SNAP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (gain_q == GAIN_TOP)); // R8

  AST_STB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(smp_stb) && !$past(snap)) |-> $stable(gain_q)); // R10

endmodule

// File: rtl/noise_gate_ctrl.sv
module noise_gate_ctrl
  import ng_pkg::*;
#(
  parameter int LVL_W          = 8,
  parameter int GAIN_W         = 6,
  parameter int SAMPLE_RATE_HZ = 48000,
  parameter int FADE_DIV       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [LVL_W-1:0]  level_i,
  input  logic              gate_en,
  input  logic [1:0]        gate_type,
  input  logic [4:0]        thr_code,
  output logic              hold_o,
  output logic              mute_o,
  output logic [GAIN_W-1:0] gain_req_o
);

  localparam int HOLD_SAMPLES = SAMPLE_RATE_HZ / 4;

  logic      below;
  logic      fade_dn;
  logic      at_min;
  ng_state_e state;

  ng_level_cmp #(.LVL_W(LVL_W)) u_cmp (
    .level_i (level_i),
    .thr_code(thr_code),
    .below_o (below)
  );

  ng_gate_fsm #(.HOLD_SAMPLES(HOLD_SAMPLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_stb    (smp_stb),
    .below      (below),
    .gate_en    (gate_en),
    .gate_type  (gate_type),
    .gain_at_min(at_min),
    .state_q    (state),
    .fade_dn    (fade_dn),
    .hold_o     (hold_o),
    .mute_o     (mute_o)
  );

  ng_gain_ramp #(.GAIN_W(GAIN_W), .FADE_DIV(FADE_DIV)) u_ramp (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_stb(smp_stb),
    .snap   (!gate_en),
    .fade_dn(fade_dn),
    .gain_q (gain_req_o),
    .at_min (at_min)
  );

  AST_HOLD_NO_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o |-> ($stable(gain_req_o) && !mute_o)); // R3

  AST_MUTE_KEEPS_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (mute_o && gate_type == 2'b01 && $past(gate_type) == 2'b01 && $past(gate_en))
      |-> $stable(gain_req_o)); // R4

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_en |=> (!hold_o && !mute_o)); // R8

  AST_NOT_BELOW_NO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && smp_stb && !below) |=> (state == ST_IDLE)); // R1

endmodule

// File: tb/noise_gate_ctrl_tb.sv
module noise_gate_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int LVL_W  = 8;
  localparam int GAIN_W = 3;
  localparam int SR     = 32;
  localparam int FD     = 2;
  localparam int HOLD   = SR / 4;
  localparam int GMAX   = (1 << GAIN_W) - 1;
  localparam int WDOG   = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic [LVL_W-1:0] level_i = '0;
  logic gate_en = 1'b0;
  logic [1:0] gate_type = 2'b00;
  logic [4:0] thr_code = 5'd0;
  logic hold_o, mute_o;
  logic [GAIN_W-1:0] gain_req_o;

  int total = 0;
  int bad = 0;
  string cur_req = "R8";

  // reference model state (0 idle,1 count,2 gated,3 muted)
  int m_st = 0, m_cnt = 0, m_gain = GMAX, m_div = 0, m_cfg = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  noise_gate_ctrl #(.LVL_W(LVL_W), .GAIN_W(GAIN_W), .SAMPLE_RATE_HZ(SR), .FADE_DIV(FD)) u_dut (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .level_i(level_i),
    .gate_en(gate_en), .gate_type(gate_type), .thr_code(thr_code),
    .hold_o(hold_o), .mute_o(mute_o), .gain_req_o(gain_req_o)
  );

  function automatic bit is_below(int lvl, int thr);
    return lvl > (153 - 3 * thr);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_gain = GMAX; m_div = 0; m_cfg = 0;
    end else begin
      int cfg, tgt, ng, nd, ty;
      bit bl;
      ty  = int'(gate_type);
      cfg = (int'(gate_en) << 2) | ty;
      bl  = is_below(int'(level_i), int'(thr_code));
      if (!gate_en) begin
        m_st = 0; m_cnt = 0; m_gain = GMAX; m_div = 0;
      end else begin
        tgt = ((m_st == 2 && ty >= 2) || (m_st == 3 && ty == 3)) ? 0 : GMAX;
        ng = m_gain; nd = m_div;
        if (smp_stb) begin
          if (m_gain == tgt) nd = 0;
          else if (m_div == FD - 1) begin nd = 0; ng = (m_gain < tgt) ? m_gain + 1 : m_gain - 1; end
          else nd = m_div + 1;
        end
        if (cfg != m_cfg) begin
          m_st = 0; m_cnt = 0;
        end else if (smp_stb) begin
          if (m_st <= 1) begin
            if (!bl) begin m_st = 0; m_cnt = 0; end
            else if (m_cnt + 1 == HOLD) begin m_st = (ty == 1) ? 3 : 2; m_cnt = 0; end
            else begin m_st = 1; m_cnt = m_cnt + 1; end
          end else if (m_st == 2) begin
            if (!bl) m_st = 0;
            else if (ty == 3 && m_gain == 0) m_st = 3;
          end else begin
            if (!bl) m_st = 0;
          end
        end
        m_gain = ng; m_div = nd;
      end
      m_cfg = cfg;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      int eh, em;
      eh = (m_st == 2 && gate_type == 2'b00) ? 1 : 0;
      em = (m_st == 3) ? 1 : 0;
      total++;
      if (int'(hold_o) != eh || int'(mute_o) != em || int'(gain_req_o) != m_gain) begin
        bad++;
        $display("FAIL %s model: hold=%0d mute=%0d gain=%0d expected hold=%0d mute=%0d gain=%0d",
                 cur_req, hold_o, mute_o, gain_req_o, eh, em, m_gain);
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic stb(input int lvl);
    level_i = LVL_W'(lvl);
    smp_stb = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic stbn(input int n, input int lvl);
    for (int i = 0; i < n; i++) stb(lvl);
  endtask

  task automatic set_cfg(input bit en, input int ty);
    gate_en = en;
    gate_type = 2'(ty);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < WDOG) begin @(posedge clk); cyc++; end
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected<%0d", cyc, WDOG);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8", "reset hold", hold_o, 0);
    chk("R8", "reset mute", mute_o, 0);
    chk("R8", "reset gain", gain_req_o, GMAX);

    // R2 / R3: threshold 10 -> limit 123
    cur_req = "R2"; thr_code = 5'd10;
    set_cfg(1, 0);
    stbn(HOLD - 1, 124);
    chk("R2", "hold before window", hold_o, 0);
    stb(123);
    stbn(HOLD - 1, 124);
    chk("R2", "hold after restart", hold_o, 0);
    stb(124);
    cur_req = "R3";
    chk("R3", "hold gated", hold_o, 1);
    chk("R3", "mute gated", mute_o, 0);
    chk("R3", "gain gated", gain_req_o, GMAX);
    cur_req = "R1";
    stb(123);
    chk("R1", "at threshold releases", hold_o, 0);

    // R1 with code 31 -> limit 60
    thr_code = 5'd31;
    stbn(HOLD, 61);
    chk("R1", "code31 gated", hold_o, 1);
    stb(60);
    chk("R1", "code31 release", hold_o, 0);
    thr_code = 5'd10;

    // R4
    cur_req = "R4";
    set_cfg(1, 1);
    stbn(HOLD, 200);
    chk("R4", "mute", mute_o, 1);
    chk("R4", "gain", gain_req_o, GMAX);
    stb(0);
    chk("R7", "mute release", mute_o, 0);

    // R5 / R10
    cur_req = "R5";
    set_cfg(1, 2);
    stbn(HOLD, 150);
    chk("R5", "gain at gating", gain_req_o, GMAX);
    cur_req = "R10";
    repeat (10) @(negedge clk);
    chk("R10", "gain idle cycles", gain_req_o, GMAX);
    cur_req = "R5";
    stbn(FD, 150);
    chk("R5", "first step", gain_req_o, GMAX - 1);
    stbn(FD * (GMAX - 1), 150);
    chk("R5", "reached min", gain_req_o, 0);
    stbn(3, 150);
    chk("R5", "no mute", mute_o, 0);
    cur_req = "R7";
    stb(123);
    stbn(FD, 100);
    chk("R7", "ramp up", gain_req_o, 1);
    stbn(FD * (GMAX - 1), 100);
    chk("R7", "back at top", gain_req_o, GMAX);

    // R6
    cur_req = "R6";
    set_cfg(1, 3);
    stbn(HOLD + FD * GMAX, 180);
    chk("R6", "min no mute yet", mute_o, 0);
    chk("R6", "min gain", gain_req_o, 0);
    stb(180);
    chk("R6", "mute after min", mute_o, 1);
    stb(20);
    chk("R7", "mute clears", mute_o, 0);
    stbn(FD * GMAX, 20);

    // R9
    cur_req = "R9";
    stbn(HOLD + FD * 2, 180);
    set_cfg(1, 0);
    chk("R9", "hold after type change", hold_o, 0);
    stbn(HOLD - 1, 180);
    chk("R9", "count restarted", hold_o, 0);
    stb(180);
    chk("R9", "gated after full window", hold_o, 1);

    // R8
    cur_req = "R8";
    set_cfg(1, 2);
    stbn(HOLD + FD * 3, 180);
    set_cfg(0, 2);
    chk("R8", "disabled gain", gain_req_o, GMAX);
    stbn(HOLD + 4, 200);
    chk("R8", "disabled hold", hold_o, 0);
    chk("R8", "disabled mute", mute_o, 0);
    chk("R8", "disabled gain held", gain_req_o, GMAX);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule